// File: doc/BRIEF.md
# Template-Driven Bundle Dispatcher with Group Hazard Check

This block takes a stream of 128-bit instruction bundles. Each bundle has a 5-bit template and three 41-bit instruction slots. The template gives the execution-unit class of each slot and says where instruction groups end. The block unpacks each accepted bundle and sends its three instructions out one at a time, in slot order. Each outgoing instruction carries a tag with the number of its instruction group. The group number moves forward after every instruction that the template marks as the last of its group. Since a group ends only at a stop, one group can cover several bundles.

Inside a group, instructions must not depend on each other through registers. A register-tracking unit keeps a 128-bit mask of the registers written so far in the current group. It raises a read-after-write flag or a write-after-write flag on any instruction that breaks this rule. The flagged instruction is still sent out; the flags only report the problem. The mask is cleared when the group ends. A bundle whose template is not in the valid set is dropped, and an error pulse reports it.

Both streams use valid/ready. An item moves on a clock edge where valid and ready are both high. While `out_valid` is high and `out_ready` is low, the output item is held unchanged. `in_ready` is high only when no bundle is being dispatched. A held bundle therefore stalls the input side until its third instruction leaves.

Top module: `bundle_dispatcher`

## Requirements
- R1: Template bits are [4:0], slot 0 is bits [45:5], slot 1 is bits [86:46] and slot 2 is bits [127:87]. The slots are emitted in the order 0, 1, 2, and `out_insn` is the slot unchanged, with `out_slot` giving its index.
- R2: Template bits [4:1] select the slot pattern; bit 0 set means a stop after slot 2. The unit codes are M=0, I=1, F=2, B=3, L=4, X=5. Patterns 0..11, listed as slots 0/1/2, are:
  - 0: MII
  - 1: MII
  - 2: MLX
  - 3: MMI
  - 4: MMI
  - 5: MFI
  - 6: MMF
  - 7: MIB
  - 8: MBB
  - 9: BBB
  - 10: MMB
  - 11: MFB
- R3: A template with pattern 12..15 is accepted and then dropped. `err_tmpl` is high for exactly the one cycle after the accept edge. No instruction is emitted for that bundle, and the group number is not changed.
- R4: `out_group` starts at 0 and goes up by 1 (wrapping at its width) after each emitted instruction that has `out_stop` set. It does not change otherwise, so a group continues across bundles that have no stop.
- R5: `out_stop` is 1 in these cases:
  - slot 1 in pattern 1;
  - slot 0 in pattern 4;
  - slot 2 when template bit 0 is set.
- R6: The register fields are: destination at bits [12:6], first source at [19:13], second source at [26:20]. `out_raw` is set when either source names a register that an earlier instruction of the same group has written.
- R7: `out_waw` is set when the destination names a register that an earlier instruction of the same group has written.
- R8: After an instruction with `out_stop` set, the set of written registers is empty again. Registers written before the stop never raise a flag after it.
- R9: Register 0 never raises a flag and is never recorded as written.
- R10: An L-class slot raises no flag and records no write.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_insn` and `out_group` stay stable. `in_ready` is low whenever `out_valid` is high.
- R12: After reset, these hold:
  - `out_valid` = 0;
  - `in_ready` = 1;
  - `err_tmpl` = 0;
  - `out_group` = 0.
- R13: `out_opcode` equals `out_insn[40:37]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Block can take a bundle |
| in_bundle | input | 128 | Template plus three slots |
| out_valid | output | 1 | Instruction offered |
| out_ready | input | 1 | Consumer takes the instruction |
| out_insn | output | 41 | Raw slot contents |
| out_opcode | output | 4 | Major opcode field |
| out_unit | output | 3 | Unit class code |
| out_slot | output | 2 | Slot index inside the bundle |
| out_group | output | GRP_W (8) | Instruction-group number |
| out_stop | output | 1 | Last instruction of its group |
| out_raw | output | 1 | Read-after-write conflict in group |
| out_waw | output | 1 | Write-after-write conflict in group |
| err_tmpl | output | 1 | One-cycle pulse for a dropped bundle |

## Verification
The assertions assume the consumer follows the valid/ready rules: a transfer happens only on an edge where both signals are high. They also assume reset is held for at least one clock edge. The stall properties rely on the block's inputs not changing the held bundle, and the bench respects this by driving `in_valid` only from a task. That task waits for `in_ready` and drops the request after exactly one accept edge. The bench changes `out_ready` only just after each rising edge, with both random and always-ready patterns. Template and register values are chosen so that the dropped codes, the stops inside a bundle, register 0, the L class and small register ranges that force conflicts all occur.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
  localparam int TMPL_W = 5;
  localparam int SLOT_W = 41;
  localparam int NSLOT  = 3;
  localparam int REG_W  = 7;
  localparam int DST_LO = 6;
  localparam int SA_LO  = 13;
  localparam int SB_LO  = 20;
  localparam int OPC_LO = 37;
  localparam int OPC_W  = 4;

  localparam logic [2:0] U_M = 3'd0;
  localparam logic [2:0] U_I = 3'd1;
  localparam logic [2:0] U_F = 3'd2;
  localparam logic [2:0] U_B = 3'd3;
  localparam logic [2:0] U_L = 3'd4;
  localparam logic [2:0] U_X = 3'd5;

  typedef struct packed {
    logic                   legal;
    logic [NSLOT-1:0]       stop;
    logic [NSLOT-1:0][2:0]  unit;
  } tmpl_dec_t;
endpackage

// File: rtl/bdec_tmpl_decode.sv
module bdec_tmpl_decode
  import bdec_pkg::*;
(
  input  logic [TMPL_W-1:0] tmpl,
  output tmpl_dec_t         dec
);
  logic [3:0] pat;
  assign pat = tmpl[TMPL_W-1:1];

  always_comb begin
    dec       = '0;
    dec.legal = 1'b1;
    // unit[2], unit[1], unit[0] are slots 2, 1, 0
    unique case (pat)
      4'd0:  dec.unit = {U_I, U_I, U_M};
      4'd1:  dec.unit = {U_I, U_I, U_M};
      4'd2:  dec.unit = {U_X, U_L, U_M};
      4'd3:  dec.unit = {U_I, U_M, U_M};
      4'd4:  dec.unit = {U_I, U_M, U_M};
      4'd5:  dec.unit = {U_I, U_F, U_M};
      4'd6:  dec.unit = {U_F, U_M, U_M};
      4'd7:  dec.unit = {U_B, U_I, U_M};
      4'd8:  dec.unit = {U_B, U_B, U_M};
      4'd9:  dec.unit = {U_B, U_B, U_B};
      4'd10: dec.unit = {U_B, U_M, U_M};
      4'd11: dec.unit = {U_B, U_F, U_M};
      default: begin
        dec.unit  = '0;
        dec.legal = 1'b0;
      end
    endcase
    dec.stop[0] = (pat == 4'd4);
    dec.stop[1] = (pat == 4'd1);
    dec.stop[2] = tmpl[0];
  end
endmodule

// File: rtl/bdec_slot_seq.sv
module bdec_slot_seq
  import bdec_pkg::*;
#(
  localparam int BUNDLE_W = TMPL_W + NSLOT * SLOT_W,
  localparam int IDX_W    = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BUNDLE_W-1:0] in_bundle,
  input  logic                cur_ready,
  output logic                cur_valid,
  output logic [SLOT_W-1:0]   cur_insn,
  output logic [2:0]          cur_unit,
  output logic                cur_stop,
  output logic [IDX_W-1:0]    cur_slot,
  output logic                err_tmpl
);
  tmpl_dec_t                      dec_in;
  tmpl_dec_t                      dec_q;
  logic [NSLOT-1:0][SLOT_W-1:0]   slots_in;
  logic [NSLOT-1:0][SLOT_W-1:0]   slots_q;
  logic [IDX_W-1:0]               idx_q;
  logic                           busy_q;
  logic                           in_fire;
  logic                           cur_fire;
  logic                           last_slot;

  bdec_tmpl_decode u_dec (
    .tmpl (in_bundle[TMPL_W-1:0]),
    .dec  (dec_in)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slots_in[g] = in_bundle[TMPL_W + g*SLOT_W +: SLOT_W];
  end

  assign in_ready  = !busy_q;
  assign in_fire   = in_valid && in_ready;
  assign cur_valid = busy_q;
  assign cur_fire  = cur_valid && cur_ready;
  assign last_slot = (idx_q == IDX_W'(NSLOT-1));

  assign cur_insn = slots_q[idx_q];
  assign cur_unit = dec_q.unit[idx_q];
  assign cur_stop = dec_q.stop[idx_q];
  assign cur_slot = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      dec_q    <= '0;
      slots_q  <= '0;
      err_tmpl <= 1'b0;
    end else begin
      err_tmpl <= in_fire && !dec_in.legal;
      if (in_fire && dec_in.legal) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        dec_q   <= dec_in;
        slots_q <= slots_in;
      end else if (cur_fire) begin
        if (last_slot) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bdec_hazard.sv
module bdec_hazard
  import bdec_pkg::*;
#(
  localparam int NREG = 1 << REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             stop,
  input  logic [2:0]       unit,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  output logic             raw,
  output logic             waw
);
  logic [NREG-1:0] written_q;
  logic            checked;

  assign checked = (unit != U_L);

  always_comb begin
    raw = checked &&
          (((src_a != '0) && written_q[src_a]) ||
           ((src_b != '0) && written_q[src_b]));
    waw = checked && (dst != '0) && written_q[dst];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      written_q <= '0;
    end else if (fire) begin
      if (stop) begin
        written_q <= '0;
      end else if (checked && (dst != '0)) begin
        written_q[dst] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bundle_dispatcher.sv
module bundle_dispatcher
  import bdec_pkg::*;
#(
  parameter int GRP_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [127:0]               in_bundle,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [SLOT_W-1:0]          out_insn,
  output logic [OPC_W-1:0]           out_opcode,
  output logic [2:0]                 out_unit,
  output logic [1:0]                 out_slot,
  output logic [GRP_W-1:0]           out_group,
  output logic                       out_stop,
  output logic                       out_raw,
  output logic                       out_waw,
  output logic                       err_tmpl
);
  logic             out_fire;
  logic [GRP_W-1:0] grp_q;

  bdec_slot_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bundle (in_bundle),
    .cur_ready (out_ready),
    .cur_valid (out_valid),
    .cur_insn  (out_insn),
    .cur_unit  (out_unit),
    .cur_stop  (out_stop),
    .cur_slot  (out_slot),
    .err_tmpl  (err_tmpl)
  );

  assign out_fire   = out_valid && out_ready;
  assign out_opcode = out_insn[OPC_LO +: OPC_W];

  bdec_hazard u_haz (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (out_fire),
    .stop  (out_stop),
    .unit  (out_unit),
    .dst   (out_insn[DST_LO +: REG_W]),
    .src_a (out_insn[SA_LO +: REG_W]),
    .src_b (out_insn[SB_LO +: REG_W]),
    .raw   (out_raw),
    .waw   (out_waw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q <= '0;
    end else if (out_fire && out_stop) begin
      grp_q <= grp_q + GRP_W'(1);
    end
  end

  assign out_group = grp_q;
endmodule

// File: rtl/bdec_checker.sv
module bdec_checker #(
  parameter int GRP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [40:0]      out_insn,
  input logic [3:0]       out_opcode,
  input logic [2:0]       out_unit,
  input logic [GRP_W-1:0] out_group,
  input logic             out_stop,
  input logic             out_raw,
  input logic             out_waw,
  input logic             err_tmpl
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_insn) && $stable(out_group));

  p_inblock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_grp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_stop |=> out_group == GRP_W'($past(out_group) + 1'b1));

  p_grp_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready && out_stop) |=> $stable(out_group));

  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_tmpl |-> !out_valid);

  p_reg0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_insn[12:6] == 7'd0) |-> !out_waw);

  p_lslot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_unit == 3'd4) |-> !out_raw && !out_waw);

  p_opc_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_opcode == out_insn[40:37]);
endmodule

bind bundle_dispatcher bdec_checker #(.GRP_W(GRP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_insn  (out_insn),
  .out_opcode(out_opcode),
  .out_unit  (out_unit),
  .out_group (out_group),
  .out_stop  (out_stop),
  .out_raw   (out_raw),
  .out_waw   (out_waw),
  .err_tmpl  (err_tmpl)
);

// File: tb/sim_bundle_dispatcher.sv
`timescale 1ns/100ps
module sim_bundle_dispatcher;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_bundle = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [40:0]  out_insn;
  logic [3:0]   out_opcode;
  logic [2:0]   out_unit;
  logic [1:0]   out_slot;
  logic [7:0]   out_group;
  logic         out_stop, out_raw, out_waw, err_tmpl;

  always #2.5 clk = ~clk;

  bundle_dispatcher #(.GRP_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bundle(in_bundle), .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .out_opcode(out_opcode), .out_unit(out_unit),
    .out_slot(out_slot), .out_group(out_group), .out_stop(out_stop),
    .out_raw(out_raw), .out_waw(out_waw), .err_tmpl(err_tmpl)
  );

  typedef struct packed {
    logic [40:0] insn;
    logic [2:0]  unit;
    logic [1:0]  slot;
    logic [7:0]  grp;
    logic        stp;
    logic        raw;
    logic        waw;
  } exp_t;

  exp_t         q[$];
  int           checks = 0;
  int           failures = 0;
  int           err_seen = 0;
  int           err_exp = 0;
  logic [127:0] m_mask = '0;
  logic [7:0]   m_grp = '0;
  logic         stall_en = 1'b0;
  logic         done = 1'b0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [40:0] mk(input logic [3:0] op, input logic [6:0] d,
                                     input logic [6:0] a, input logic [6:0] b);
    return {op, 10'h0, b, a, d, 6'h0};
  endfunction

  function automatic logic [2:0] unit_of(input logic [3:0] p, input int s);
    logic [8:0] u;
    case (p)
      0, 1:   u = {3'd1, 3'd1, 3'd0};
      2:      u = {3'd5, 3'd4, 3'd0};
      3, 4:   u = {3'd1, 3'd0, 3'd0};
      5:      u = {3'd1, 3'd2, 3'd0};
      6:      u = {3'd2, 3'd0, 3'd0};
      7:      u = {3'd3, 3'd1, 3'd0};
      8:      u = {3'd3, 3'd3, 3'd0};
      9:      u = {3'd3, 3'd3, 3'd3};
      10:     u = {3'd3, 3'd0, 3'd0};
      default: u = {3'd3, 3'd2, 3'd0};
    endcase
    return u[s*3 +: 3];
  endfunction

  // Driver: models expected items (R1..R10) and pushes them before sending
  task automatic send(input logic [4:0] t, input logic [40:0] s0,
                      input logic [40:0] s1, input logic [40:0] s2);
    logic [40:0] sl[3];
    logic [3:0]  p;
    sl[0] = s0; sl[1] = s1; sl[2] = s2;
    p = t[4:1];
    if (p >= 4'd12) begin
      err_exp++;
    end else begin
      for (int i = 0; i < 3; i++) begin
        exp_t e;
        logic [6:0] d, a, b;
        d = sl[i][12:6]; a = sl[i][19:13]; b = sl[i][26:20];
        e.insn = sl[i];
        e.unit = unit_of(p, i);
        e.slot = 2'(i);
        e.grp  = m_grp;
        e.stp  = (i == 2 && t[0]) || (i == 1 && p == 4'd1) || (i == 0 && p == 4'd4);
        if (e.unit != 3'd4) begin
          e.raw = (a != 0 && m_mask[a]) || (b != 0 && m_mask[b]);
          e.waw = (d != 0 && m_mask[d]);
        end else begin
          e.raw = 1'b0; e.waw = 1'b0;
        end
        if (e.stp) begin
          m_mask = '0;
          m_grp  = m_grp + 8'd1;
        end else if (e.unit != 3'd4 && d != 0) begin
          m_mask[d] = 1'b1;
        end
        q.push_back(e);
      end
    end
    @(negedge clk);
    in_bundle = {s2, s1, s0, t};
    in_valid  = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (p >= 4'd12) chk(err_tmpl == 1'b1, "R3 err pulse", err_tmpl, 1);
  endtask

  // Ready driver, changes just after each rising edge
  initial forever begin
    @(posedge clk);
    #1 out_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
  end

  // Monitor / scoreboard
  logic        pv = 1'b0, pr = 1'b0;
  logic [40:0] pinsn = '0;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (err_tmpl) err_seen++;
      if (pv && !pr) begin
        chk(out_valid && out_insn == pinsn, "R11 hold under stall", out_insn, pinsn);
      end
      if (out_valid) chk(!in_ready, "R11 in_ready low while busy", in_ready, 0);
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1 unexpected output", out_insn, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_insn == e.insn, "R1 insn", out_insn, e.insn);
          chk(out_slot == e.slot, "R1 slot", out_slot, e.slot);
          chk(out_unit == e.unit, "R2 unit", out_unit, e.unit);
          chk(out_group == e.grp, "R4 group", out_group, e.grp);
          chk(out_stop == e.stp, "R5 stop", out_stop, e.stp);
          chk(out_raw == e.raw, "R6 R8 R9 R10 raw", out_raw, e.raw);
          chk(out_waw == e.waw, "R7 R8 R9 R10 waw", out_waw, e.waw);
          chk(out_opcode == out_insn[40:37], "R13 opcode", out_opcode, out_insn[40:37]);
        end
      end
      pv = out_valid; pr = out_ready; pinsn = out_insn;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0, "R12 out_valid", out_valid, 0);
    chk(in_ready == 1, "R12 in_ready", in_ready, 1);
    chk(err_tmpl == 0, "R12 err_tmpl", err_tmpl, 0);
    chk(out_group == 0, "R12 group", out_group, 0);

    // R6: RAW inside one bundle, pattern 0 with end stop
    send({4'd0, 1'b1}, mk(4'h1, 7'd5, 7'd1, 7'd2), mk(4'h2, 7'd6, 7'd5, 7'd3), mk(4'h3, 7'd7, 7'd4, 7'd6));
    // R7: WAW, pattern 3 no stop
    send({4'd3, 1'b0}, mk(4'h4, 7'd9, 7'd1, 7'd1), mk(4'h5, 7'd9, 7'd2, 7'd3), mk(4'h6, 7'd8, 7'd0, 7'd0));
    // R4: group spans bundles; R6 read of r9 written in previous bundle
    send({4'd5, 1'b1}, mk(4'h7, 7'd10, 7'd9, 7'd0), mk(4'h8, 7'd11, 7'd8, 7'd0), mk(4'h9, 7'd12, 7'd0, 7'd0));
    // R5 R8: stop after slot 1 in pattern 1
    send({4'd1, 1'b0}, mk(4'hA, 7'd20, 7'd0, 7'd0), mk(4'hB, 7'd21, 7'd0, 7'd0), mk(4'hC, 7'd22, 7'd20, 7'd21));
    // R5 R8: stop after slot 0 in pattern 4
    send({4'd4, 1'b1}, mk(4'hD, 7'd30, 7'd0, 7'd0), mk(4'hE, 7'd30, 7'd30, 7'd0), mk(4'hF, 7'd31, 7'd22, 7'd0));
    // R9: register 0 repeatedly written and read
    send({4'd6, 1'b1}, mk(4'h1, 7'd0, 7'd0, 7'd0), mk(4'h2, 7'd0, 7'd0, 7'd0), mk(4'h3, 7'd0, 7'd0, 7'd0));
    // R10: L slot neither flagged nor recorded
    send({4'd2, 1'b1}, mk(4'h4, 7'd40, 7'd0, 7'd0), mk(4'h5, 7'd40, 7'd40, 7'd41), mk(4'h6, 7'd42, 7'd41, 7'd0));
    // R3: illegal codes, then a legal bundle sees unchanged group
    send({4'd13, 1'b0}, mk(4'h1, 7'd1, 7'd1, 7'd1), 41'h0, 41'h0);
    send({4'd15, 1'b1}, 41'h0, 41'h0, 41'h0);
    send({4'd9, 1'b1}, mk(4'h7, 7'd1, 7'd0, 7'd0), mk(4'h8, 7'd2, 7'd1, 7'd0), mk(4'h9, 7'd3, 7'd2, 7'd0));

    // R2 R11: sweep all 32 codes with random stalls and small register range
    stall_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      for (int t = 0; t < 32; t++) begin
        logic [40:0] r[3];
        for (int i = 0; i < 3; i++)
          r[i] = mk(4'($urandom), 7'($urandom % 6), 7'($urandom % 6), 7'($urandom % 6));
        send(5'(t), r[0], r[1], r[2]);
      end
    end

    for (int w = 0; w < 2000 && q.size() != 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R1 all items emitted", q.size(), 0);
    chk(err_seen == err_exp, "R3 error pulse count", err_seen, err_exp);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule